// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and presents them to a processor as a single 4-bit interrupt level. Each line has its own 2-bit trigger field. The field selects one of four detection types: active-high level, active-low level, rising edge or falling edge. Each request passes through a two-flop synchronizer before detection. A detected request is held in a pending register that software can read.

Software sees five 32-bit word registers through a simple bus. The bus has an active-low select, a write strobe and a word index, which is byte-address bits [9:2]. Through these registers software sets the trigger fields, reads the pending bits, and clears edge-detected requests by writing ones. It can also mask single lines or the whole level output. The level output is the number of the highest-numbered line that is both pending and unmasked.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: Synchronous active-high reset sets these values:
  - all pending bits to 0;
  - all trigger fields to 00;
  - the per-line masks (mask register bits [15:1]) to 1;
  - the global mask (bit 0) to 0.
  The level output is then 0.
- R2: A write takes effect at the rising clock edge while `bus_sel_n` is 0 and `bus_wr` is 1. `bus_rdata` shows the register at `bus_idx` while `bus_sel_n` is 0. It reads 0 when `bus_sel_n` is 1 or when the index is not one of 0x00 to 0x04.
- R3: The trigger fields are laid out as follows:
  - Index 0x00 holds lines 15 down to 8 in bit pairs, with line 15 at [15:14] and line 8 at [1:0].
  - Index 0x01 holds lines 7 down to 1, with line 7 at [15:14] and line 1 at [3:2].
  - Bits [1:0] of index 0x01 always read 0.
  - The encoding is 00 = active-high level, 01 = active-low level, 10 = rising edge, 11 = falling edge.
- R4: In both level modes the pending bit equals the active level of the input, delayed by three clock edges (two synchronizer stages and the pending register). Writing to the clear register does not remove it while the level is active.
- R5: In mode 10 a 0-to-1 input transition sets the pending bit, and in mode 11 a 1-to-0 transition sets it. The opposite transition does not set it. Once set, the bit stays set after the input returns.
- R6: Writing to index 0x03 changes pending bits as follows:
  - A 1 in bit n (n from 1 to 15) clears the edge-mode pending bit of line n.
  - A 0 in bit n leaves that bit unchanged.
  - If a detected edge and a clear of the same line fall in the same cycle, the bit stays set.
  Index 0x03 reads as 0.
- R7: Index 0x02 is read-only. Its bits [15:1] show the pending bits of lines 15 to 1, and bit 0 reads 0. A write to index 0x02 changes nothing.
- R8: In the mask register at index 0x04, bit n (n from 1 to 15) set to 1 keeps line n out of the level output. The pending bit of line n stays visible at index 0x02.
- R9: `irq_level` equals the highest line number whose pending bit is 1 and whose mask bit is 0. It is 0 if there is no such line.
- R10: While mask register bit 0 is 1, `irq_level` is 0 whatever is pending.
- R11: Bits [31:16] are ignored on every write and read as 0 from every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Register select, active low |
| bus_wr | input | 1 | Write strobe, 1 = write |
| bus_idx | input | 8 | Word index (byte address bits [9:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index |
| irq_in | input | 15 | Request lines, bit n is line n (n = 1..15) |
| irq_level | output | 4 | Encoded level of highest unmasked pending line |

## Verification
Four detection cases are each driven with both input polarities:
- A high pulse and a low pulse on a line in active-high mode.
- A high pulse and a low pulse on a line in active-low mode.
- A rise and a fall on a line in rising-edge mode.
- A rise and a fall on a line in falling-edge mode.

Each case also gets a clear written while the input is still asserted, which separates level behaviour (the bit stays) from edge behaviour (the bit is cleared). The priority encoder sees several mixes of two and three pending lines, with per-line masks and the global mask switched between them. This shows that the highest unmasked line is chosen, not simply the highest pending line. A clear write is timed onto the same edge that latches a new rising transition, which shows whether the edge or the clear takes precedence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NCH     = 15;
    localparam int LVL_W   = $clog2(NCH + 1);
    localparam int BUS_W   = 32;
    localparam int IDX_W   = 8;
    localparam int REG_W   = 16;
    localparam int HI_BASE = 8;

    localparam logic [IDX_W-1:0] IDX_MODE_HI = 8'h00;
    localparam logic [IDX_W-1:0] IDX_MODE_LO = 8'h01;
    localparam logic [IDX_W-1:0] IDX_SENSE   = 8'h02;
    localparam logic [IDX_W-1:0] IDX_CLEAR   = 8'h03;
    localparam logic [IDX_W-1:0] IDX_MASK    = 8'h04;

    localparam logic [REG_W-1:0] MASK_RST = {{NCH{1'b1}}, 1'b0};

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    // Bit offset of a line's trigger field inside its register.
    function automatic int mode_ofs(input int ch);
        return (ch >= HI_BASE) ? 2 * (ch - HI_BASE) : 2 * ch;
    endfunction

    function automatic logic mode_in_hi(input int ch);
        return ch >= HI_BASE;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [W:1] raw,
    output logic [W:1] cur,
    output logic [W:1] prv
);
    logic [W:1] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prv    <= '0;
        end else begin
            meta_q <= raw;
            cur    <= meta_q;
            prv    <= cur;
        end
    end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int W = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  trig_mode_e [W:1]     mode,
    input  logic       [W:1]     cur,
    input  logic       [W:1]     prv,
    input  logic       [W:1]     clr,
    output logic       [W:1]     pend
);
    for (genvar g = 1; g <= W; g++) begin : g_ch
        logic rise, fall;
        assign rise = cur[g] & ~prv[g];
        assign fall = ~cur[g] & prv[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else begin
                unique case (mode[g])
                    TRIG_HIGH: pend[g] <= cur[g];
                    TRIG_LOW:  pend[g] <= ~cur[g];
                    TRIG_RISE: pend[g] <= rise | (pend[g] & ~clr[g]);
                    TRIG_FALL: pend[g] <= fall | (pend[g] & ~clr[g]);
                    default:   pend[g] <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int W  = 15,
    parameter int LW = 4
) (
    input  logic [W:1]    req,
    input  logic          gmask,
    output logic [LW-1:0] lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 1; i <= W; i++) begin
            if (req[i]) lvl = LW'(i);
        end
        if (gmask) lvl = '0;
    end
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel_n,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NCH:1]     irq_in,
    output logic [LVL_W-1:0] irq_level
);
    bus_req_t         req;
    trig_mode_e [NCH:1] mode_q;
    logic [REG_W-1:0] mask_q;
    logic [NCH:1]     cur, prv, pend_q, clr;
    logic             wr_hi, wr_lo, wr_mask, wr_clr;
    logic [REG_W-1:0] mode_hi_rd, mode_lo_rd;

    assign req = '{sel: ~bus_sel_n, wr: bus_wr, idx: bus_idx, wdata: bus_wdata};

    assign wr_hi   = req.sel & req.wr & (req.idx == IDX_MODE_HI);
    assign wr_lo   = req.sel & req.wr & (req.idx == IDX_MODE_LO);
    assign wr_mask = req.sel & req.wr & (req.idx == IDX_MASK);
    assign wr_clr  = req.sel & req.wr & (req.idx == IDX_CLEAR);
    assign clr     = wr_clr ? req.wdata[NCH:1] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= NCH; i++) mode_q[i] <= TRIG_HIGH;
            mask_q <= MASK_RST;
        end else begin
            for (int i = 1; i <= NCH; i++) begin
                if (mode_in_hi(i) ? wr_hi : wr_lo)
                    mode_q[i] <= trig_mode_e'(req.wdata[mode_ofs(i) +: 2]);
            end
            if (wr_mask) mask_q <= req.wdata[REG_W-1:0];
        end
    end

    always_comb begin
        mode_hi_rd = '0;
        mode_lo_rd = '0;
        for (int i = 1; i <= NCH; i++) begin
            if (mode_in_hi(i)) mode_hi_rd[mode_ofs(i) +: 2] = mode_q[i];
            else               mode_lo_rd[mode_ofs(i) +: 2] = mode_q[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (req.sel) begin
            unique case (req.idx)
                IDX_MODE_HI: bus_rdata[REG_W-1:0] = mode_hi_rd;
                IDX_MODE_LO: bus_rdata[REG_W-1:0] = mode_lo_rd;
                IDX_SENSE:   bus_rdata[NCH:1]     = pend_q;
                IDX_MASK:    bus_rdata[REG_W-1:0] = mask_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    irqc_sync #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (irq_in),
        .cur (cur),
        .prv (prv)
    );

    irqc_pend #(.W(NCH)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .cur  (cur),
        .prv  (prv),
        .clr  (clr),
        .pend (pend_q)
    );

    irqc_prio #(.W(NCH), .LW(LVL_W)) u_prio (
        .req   (pend_q & ~mask_q[NCH:1]),
        .gmask (mask_q[0]),
        .lvl   (irq_level)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel_n,
    input logic [IDX_W-1:0]   bus_idx,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic [LVL_W-1:0]   irq_level,
    input logic [NCH:1]       pend,
    input logic [REG_W-1:0]   mask,
    input trig_mode_e [NCH:1] mode,
    input logic [NCH:1]       cur,
    input logic [NCH:1]       prv,
    input logic [NCH:1]       clr
);
    logic [REG_W-1:0] pv;
    assign pv = {pend, 1'b0};

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == MASK_RST && pend == '0 && irq_level == '0));

    assert_gmask_zero_R10: assert property (@(posedge clk) disable iff (rst)
        mask[0] |-> irq_level == '0);

    assert_level_source_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (pv[irq_level] && !mask[irq_level]));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:REG_W] == '0);

    assert_clear_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel_n && bus_idx == IDX_CLEAR) |-> bus_rdata == '0);

    for (genvar g = 1; g <= NCH; g++) begin : g_ch
        assert_level_max_R9: assert property (@(posedge clk) disable iff (rst)
            (pend[g] && !mask[g] && !mask[0]) |-> irq_level >= LVL_W'(g));

        assert_high_follow_R4: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_HIGH) |=> pend[g] == $past(cur[g]));

        assert_low_follow_R4: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_LOW) |=> pend[g] == !$past(cur[g]));

        assert_rise_sets_R5: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_RISE && cur[g] && !prv[g]) |=> pend[g]);

        assert_fall_sets_R5: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_FALL && !cur[g] && prv[g]) |=> pend[g]);

        assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
            ((mode[g] == TRIG_RISE || mode[g] == TRIG_FALL) && pend[g] && !clr[g])
            |=> pend[g]);

        assert_rise_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_RISE && clr[g] && !(cur[g] && !prv[g])) |=> !pend[g]);

        assert_fall_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (mode[g] == TRIG_FALL && clr[g] && !(!cur[g] && prv[g])) |=> !pend[g]);
    end
endmodule

bind irq_trigger_ctrl irqc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel_n (bus_sel_n),
    .bus_idx   (bus_idx),
    .bus_rdata (bus_rdata),
    .irq_level (irq_level),
    .pend      (pend_q),
    .mask      (mask_q),
    .mode      (mode_q),
    .cur       (cur),
    .prv       (prv),
    .clr       (clr)
);

// File: tb/irq_trigger_ctrl_tb.sv
module irq_trigger_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:1] irq_in = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_trigger_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel_n (bus_sel_n),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_level (irq_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] idx, input logic [31:0] data);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_wr = 1'b1; bus_idx = idx; bus_wdata = data;
        @(negedge clk);
        bus_sel_n = 1'b1; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] idx, output logic [31:0] data);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_wr = 1'b0; bus_idx = idx;
        #1 data = bus_rdata;
        bus_sel_n = 1'b1;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_irq(input int ch, input logic v);
        @(negedge clk);
        irq_in[ch] = v;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(8'h02, d); check("R1 pending after reset", d, 32'h0);
        bus_read(8'h04, d); check("R1 mask after reset", d, 32'h0000_FFFE);
        bus_read(8'h00, d); check("R1 mode hi after reset", d, 32'h0);
        bus_read(8'h01, d); check("R1 mode lo after reset", d, 32'h0);
        check("R1 level after reset", {28'h0, irq_level}, 32'h0);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_FFF6);
        set_irq(3, 1'b1); settle();
        bus_read(8'h02, d); check("R4 high level sets", d, 32'h8);
        check("R9 level line 3", {28'h0, irq_level}, 32'd3);
        bus_write(8'h03, 32'h8); settle();
        bus_read(8'h02, d); check("R4 clear ignored while active", d, 32'h8);
        set_irq(3, 1'b0); settle();
        bus_read(8'h02, d); check("R4 high level drops", d, 32'h0);
        check("R9 level none", {28'h0, irq_level}, 32'd0);
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        bus_write(8'h01, 32'h0000_0400); settle();
        bus_read(8'h02, d); check("R4 low level sets", d, 32'h20);
        bus_read(8'h01, d); check("R3 mode lo readback", d, 32'h400);
        check("R8 masked line 5 not in level", {28'h0, irq_level}, 32'd0);
        bus_write(8'h03, 32'h20); settle();
        bus_read(8'h02, d); check("R4 low level clear ignored", d, 32'h20);
        set_irq(5, 1'b1); settle();
        bus_read(8'h02, d); check("R4 low level drops", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        bus_write(8'h00, 32'h0000_002C);
        bus_read(8'h00, d); check("R3 mode hi readback", d, 32'h2C);
        set_irq(10, 1'b1); settle();
        bus_read(8'h02, d); check("R5 rise sets", d, 32'h400);
        set_irq(10, 1'b0); settle();
        bus_read(8'h02, d); check("R5 rise held", d, 32'h400);
        bus_write(8'h03, 32'h400); settle();
        bus_read(8'h02, d); check("R6 clear edge", d, 32'h0);
        set_irq(9, 1'b1); settle();
        bus_read(8'h02, d); check("R5 fall mode ignores rise", d, 32'h0);
        set_irq(9, 1'b0); settle();
        bus_read(8'h02, d); check("R5 fall sets", d, 32'h200);
        bus_write(8'h03, 32'h0); settle();
        bus_read(8'h02, d); check("R6 zero write keeps", d, 32'h200);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        set_irq(10, 1'b1); settle();
        bus_write(8'h04, 32'h0); @(negedge clk);
        check("R9 highest of 10 and 9", {28'h0, irq_level}, 32'd10);
        bus_write(8'h04, 32'h400); @(negedge clk);
        check("R8 mask line 10 level", {28'h0, irq_level}, 32'd9);
        bus_read(8'h02, d); check("R8 masked line still pending", d, 32'h600);
        bus_write(8'h04, 32'h401); @(negedge clk);
        check("R10 global mask", {28'h0, irq_level}, 32'd0);
        bus_write(8'h04, 32'h0); @(negedge clk);
        check("R10 global unmask", {28'h0, irq_level}, 32'd10);
        set_irq(15, 1'b1); settle();
        check("R9 line 15 wins", {28'h0, irq_level}, 32'd15);
        set_irq(15, 1'b0); settle();
        check("R9 back to line 10", {28'h0, irq_level}, 32'd10);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        bus_write(8'h03, 32'h400); settle();
        bus_read(8'h02, d); check("R6 clear while held high", d, 32'h200);
        set_irq(10, 1'b0); settle();
        @(negedge clk); irq_in[10] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_wr = 1'b1; bus_idx = 8'h03; bus_wdata = 32'h400;
        @(negedge clk);
        bus_sel_n = 1'b1; bus_wr = 1'b0; bus_wdata = '0;
        settle();
        bus_read(8'h02, d); check("R6 edge wins over clear", d, 32'h600);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        bus_write(8'h00, 32'hFFFF_002C);
        bus_read(8'h00, d); check("R11 upper bits ignored", d, 32'h2C);
        bus_write(8'h01, 32'h0000_0403);
        bus_read(8'h01, d); check("R3 reserved low pair", d, 32'h400);
        bus_write(8'h02, 32'h0000_FFFF); settle();
        bus_read(8'h02, d); check("R7 sense write no effect", d, 32'h600);
        bus_read(8'h03, d); check("R6 clear reads zero", d, 32'h0);
        bus_read(8'h07, d); check("R2 unmapped reads zero", d, 32'h0);
        @(negedge clk); bus_idx = 8'h02; bus_sel_n = 1'b1; #1;
        check("R2 deselected reads zero", bus_rdata, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d); check("R11 mask upper ignored", d, 32'h0000_FFFF);
        check("R10 all masked level", {28'h0, irq_level}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_level_high();
        t_level_low();
        t_edge();
        t_priority();
        t_clear_race();
        t_bus();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule